// File: doc/BRIEF.md
# Instruction-Tick Timer with Shared Prescaler

An 8-bit up-counter for a small microcontroller core. It advances either once per instruction cycle (four system clocks, tracked by an internal phase counter) or on a chosen edge of an external clock pin that is first synchronized into the system clock domain. One 8-bit prescaler belongs to either the timer or a watchdog path, never both. When the timer owns it, the timer advances once per 2, 4, ... 256 source events. When the watchdog owns it, the timer runs 1:1 and the prescaler divides pulses from the watchdog oscillator by 1, 2, ... 128 into a watchdog tick.

Software loads the count through a write port. A load stops counting for the next two instruction cycles and, if the timer owns the prescaler, empties it. A watchdog clear empties the prescaler when the watchdog owns it. An increment from 255 wraps to 0 and sets a sticky overflow flag. The prescaler itself is invisible to software.

Top module: `cyc_tmr`

## Requirements
- R1: After reset the count is 0x00, the overflow flag is 0, the watchdog tick is 0 and the prescaler is empty.
- R2: With internal source (`cfg_src_ext`=0) and the prescaler on the watchdog (`cfg_psc_to_wdt`=1), the count rises by exactly one every 4 clocks. The instruction tick is phase 3 of the 2-bit phase counter, and its increment becomes visible two clocks later, at the phase-1 edge.
- R3: With the prescaler on the timer (`cfg_psc_to_wdt`=0), the count rises once per 2^(`cfg_ratio`+1) source events, so once per 8·2^`cfg_ratio` clocks on the internal source.
- R4: With external source, `cfg_fall_edge`=0 counts only rising edges of `ext_clk` and `cfg_fall_edge`=1 counts only falling edges.
- R5: A clock with `tmr_we`=1 loads `tmr_wdata` into the count at that edge. It drops every increment request that arises during the next two instruction ticks. On the internal 1:1 source, with the load at a phase-2 edge, the next increment therefore lands 11 clocks after the load.
- R6: With the prescaler on the timer, a load empties the prescaler. On the internal 1:4 source, with the load at a phase-2 edge, the next increment lands 15 clocks after the load.
- R7: An increment from 0xFF to 0x00 sets `tmr_ovf`. The flag holds until a clock with `ovf_clr`=1. A wrap in the same clock as `ovf_clr` leaves the flag set.
- R8: With the prescaler on the watchdog, `wdt_tick` pulses for one clock, one clock after every 2^`cfg_ratio`-th `wdt_osc` pulse counted from an empty prescaler.
- R9: With the prescaler on the watchdog, `wdt_clr` empties the prescaler and suppresses a tick in that clock. A timer load leaves the prescaler untouched.
- R10: With the prescaler on the timer, every `wdt_osc` pulse gives a `wdt_tick` one clock later.
- R11: `ext_clk` passes two synchronizer flops and an edge flop, and requests are applied only on odd phases. A pin edge therefore changes the count no earlier than 4 and no later than 5 clock edges after it is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four per instruction cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_src_ext | input | 1 | 1: count external pin edges, 0: count instruction ticks |
| cfg_fall_edge | input | 1 | 1: falling edges of the pin, 0: rising edges |
| cfg_psc_to_wdt | input | 1 | 1: prescaler on watchdog path, 0: prescaler on timer |
| cfg_ratio | input | 3 | Prescaler ratio select |
| tmr_we | input | 1 | Load strobe for the count |
| tmr_wdata | input | 8 | Value to load |
| ovf_clr | input | 1 | Clears the overflow flag |
| wdt_clr | input | 1 | Watchdog clear command |
| wdt_osc | input | 1 | One-clock pulses from the watchdog oscillator |
| ext_clk | input | 1 | Asynchronous external count input |
| tmr_count | output | 8 | Current count |
| tmr_ovf | output | 1 | Sticky overflow flag |
| wdt_tick | output | 1 | Prescaled watchdog pulse |

## Verification
A load shows on the count at its own edge. The first increment after a load is due 11 clocks later (1:1) or 15 clocks later (1:4 with the prescaler cleared), and a pin edge shows 4 to 5 edges after capture. A watchdog tick is due one edge after the oscillator pulse that completes the ratio. The bench can see the phase counter only through the count, so each timing test first waits for a count change, which always falls on a phase-1 edge, and counts edges from that point. Rate checks sample whole multiples of the increment period after such a change, and every sample is taken on the falling clock edge.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
    localparam int TMR_W  = 8;
    localparam int PH_W   = 2;
    localparam int HOLD_W = 2;
    localparam logic [HOLD_W-1:0] HOLD_TICKS = 2'd2;

    typedef struct packed {
        logic [PH_W-1:0]   phase;
        logic [TMR_W-1:0]  count;
        logic [HOLD_W-1:0] hold;
        logic              pend;
        logic              ovf;
        logic              wdt_tick;
    } ctmr_state_t;
endpackage

// File: rtl/ctmr_pin_sync.sv
module ctmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_ev
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;
    logic            cur, old;

    always_comb begin
        sh_d    = {sh_q[SH_W-2:0], pin};
        cur     = sh_q[STAGES-1];
        old     = sh_q[STAGES];
        edge_ev = fall_sel ? (~cur & old) : (cur & ~old);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/ctmr_prescaler.sv
module ctmr_prescaler #(
    parameter int PSC_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             to_wdt,
    input  logic [SEL_W-1:0] sel,
    input  logic             tmr_ev,
    input  logic             wdt_ev,
    input  logic             clr,
    output logic             tmr_inc,
    output logic             wdt_hit
);
    logic [PSC_W-1:0] psc_d, psc_q;
    logic [PSC_W-1:0] mask_tmr, mask_wdt;
    logic             step, hit_t, hit_w;

    always_comb begin
        for (int i = 0; i < PSC_W; i++) begin
            mask_tmr[i] = (i <= int'(sel));
            mask_wdt[i] = (i <  int'(sel));
        end
        hit_t = ((psc_q & mask_tmr) == mask_tmr);
        hit_w = ((psc_q & mask_wdt) == mask_wdt);
        step  = to_wdt ? wdt_ev : tmr_ev;

        if (clr)       psc_d = '0;
        else if (step) psc_d = psc_q + 1'b1;
        else           psc_d = psc_q;

        tmr_inc = to_wdt ? tmr_ev : (tmr_ev & hit_t & ~clr);
        wdt_hit = to_wdt ? (wdt_ev & hit_w & ~clr) : wdt_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
    end
endmodule

// File: rtl/cyc_tmr.sv
module cyc_tmr
    import ctmr_pkg::*;
#(
    parameter int PSC_W       = 8,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_src_ext,
    input  logic             cfg_fall_edge,
    input  logic             cfg_psc_to_wdt,
    input  logic [SEL_W-1:0] cfg_ratio,
    input  logic             tmr_we,
    input  logic [TMR_W-1:0] tmr_wdata,
    input  logic             ovf_clr,
    input  logic             wdt_clr,
    input  logic             wdt_osc,
    input  logic             ext_clk,
    output logic [TMR_W-1:0] tmr_count,
    output logic             tmr_ovf,
    output logic             wdt_tick
);
    localparam logic [PH_W-1:0] PH_LAST = '1;

    ctmr_state_t st_d, st_q;
    logic ext_edge, inst_tick, src_ev, psc_clr;
    logic tmr_inc, wdt_hit, apply, wrap;

    ctmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_clk),
        .fall_sel (cfg_fall_edge),
        .edge_ev  (ext_edge)
    );

    ctmr_prescaler #(.PSC_W(PSC_W), .SEL_W(SEL_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .to_wdt  (cfg_psc_to_wdt),
        .sel     (cfg_ratio),
        .tmr_ev  (src_ev),
        .wdt_ev  (wdt_osc),
        .clr     (psc_clr),
        .tmr_inc (tmr_inc),
        .wdt_hit (wdt_hit)
    );

    always_comb begin
        inst_tick = (st_q.phase == PH_LAST);
        src_ev    = cfg_src_ext ? ext_edge : inst_tick;
        psc_clr   = cfg_psc_to_wdt ? wdt_clr : tmr_we;
        apply     = st_q.pend & st_q.phase[0];
        wrap      = ~tmr_we & apply & (st_q.count == '1);

        st_d       = st_q;
        st_d.phase = st_q.phase + 1'b1;

        if (tmr_we) begin
            st_d.count = tmr_wdata;
            st_d.hold  = HOLD_TICKS;
            st_d.pend  = 1'b0;
        end else begin
            if (inst_tick && (st_q.hold != '0))
                st_d.hold = st_q.hold - 1'b1;
            if (apply) begin
                st_d.pend  = 1'b0;
                st_d.count = st_q.count + 1'b1;
            end
            if (tmr_inc && (st_q.hold == '0))
                st_d.pend = 1'b1;
        end

        if (wrap)         st_d.ovf = 1'b1;
        else if (ovf_clr) st_d.ovf = 1'b0;

        st_d.wdt_tick = wdt_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmr_count = st_q.count;
    assign tmr_ovf   = st_q.ovf;
    assign wdt_tick  = st_q.wdt_tick;
endmodule

// File: rtl/ctmr_checker.sv
module ctmr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_psc_to_wdt,
    input logic       tmr_we,
    input logic [7:0] tmr_wdata,
    input logic       ovf_clr,
    input logic       wdt_clr,
    input logic       wdt_osc,
    input logic [7:0] tmr_count,
    input logic       tmr_ovf,
    input logic       wdt_tick
);
    a_r5_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_we |=> tmr_count == $past(tmr_wdata));

    a_r5_hold_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tmr_we) && !tmr_we) |=> $stable(tmr_count));

    a_r2_step_of_one: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_we |=> (tmr_count == $past(tmr_count)) ||
                    (tmr_count == $past(tmr_count) + 8'd1));

    a_r7_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_we && tmr_count == 8'hFF) |=> (tmr_count == 8'hFF) || tmr_ovf);

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ovf && !ovf_clr) |=> tmr_ovf);

    a_r9_clear_blocks_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_psc_to_wdt && wdt_clr) |=> !wdt_tick);

    a_r10_bypass_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_psc_to_wdt |=> wdt_tick == $past(wdt_osc));
endmodule

bind cyc_tmr ctmr_checker u_ctmr_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_psc_to_wdt (cfg_psc_to_wdt),
    .tmr_we         (tmr_we),
    .tmr_wdata      (tmr_wdata),
    .ovf_clr        (ovf_clr),
    .wdt_clr        (wdt_clr),
    .wdt_osc        (wdt_osc),
    .tmr_count      (tmr_count),
    .tmr_ovf        (tmr_ovf),
    .wdt_tick       (wdt_tick)
);

// File: tb/cyc_tmr_bench.sv
`timescale 1ns/1ps
module cyc_tmr_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_src_ext = 1'b0, cfg_fall_edge = 1'b0, cfg_psc_to_wdt = 1'b1;
    logic [2:0] cfg_ratio = 3'd0;
    logic       tmr_we = 1'b0;
    logic [7:0] tmr_wdata = 8'h00;
    logic       ovf_clr = 1'b0, wdt_clr = 1'b0, wdt_osc = 1'b0, ext_clk = 1'b0;
    logic [7:0] tmr_count;
    logic       tmr_ovf, wdt_tick;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cyc_tmr u_cyc_tmr (
        .clk(clk), .rst_n(rst_n), .cfg_src_ext(cfg_src_ext), .cfg_fall_edge(cfg_fall_edge),
        .cfg_psc_to_wdt(cfg_psc_to_wdt), .cfg_ratio(cfg_ratio), .tmr_we(tmr_we),
        .tmr_wdata(tmr_wdata), .ovf_clr(ovf_clr), .wdt_clr(wdt_clr), .wdt_osc(wdt_osc),
        .ext_clk(ext_clk), .tmr_count(tmr_count), .tmr_ovf(tmr_ovf), .wdt_tick(wdt_tick)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // waits for the count to move; that edge is always a phase-1 edge
    task automatic sync_change(input string req);
        logic [7:0] prev;
        bit seen;
        prev = tmr_count;
        seen = 1'b0;
        for (int i = 0; i < 800 && !seen; i++) begin
            @(negedge clk);
            if (tmr_count != prev) seen = 1'b1;
        end
        chk({req, " count moves"}, int'(seen), 1);
    endtask

    task automatic load(input logic [7:0] v);
        tmr_wdata = v;
        tmr_we = 1'b1;
        step(1);
        tmr_we = 1'b0;
    endtask

    task automatic osc_pulse(output logic t);
        wdt_osc = 1'b1;
        step(1);
        t = wdt_tick;
        wdt_osc = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 count", int'(tmr_count), 0);
        chk("R1 flag", int'(tmr_ovf), 0);
        chk("R1 tick", int'(wdt_tick), 0);
    endtask

    task automatic t_internal;
        logic [7:0] c;
        cfg_src_ext = 1'b0; cfg_psc_to_wdt = 1'b1;
        sync_change("R2");
        c = tmr_count;
        step(3);
        chk("R2 between ticks", int'(tmr_count), int'(c));
        step(1);
        chk("R2 one tick", int'(tmr_count), int'(c + 8'd1));
        step(12);
        chk("R2 four ticks", int'(tmr_count), int'(c + 8'd4));
    endtask

    task automatic t_load_hold;
        cfg_src_ext = 1'b0; cfg_psc_to_wdt = 1'b1;
        sync_change("R5");
        step(4);
        load(8'h40);
        chk("R5 loaded", int'(tmr_count), 'h40);
        step(10);
        chk("R5 held", int'(tmr_count), 'h40);
        step(1);
        chk("R5 first step", int'(tmr_count), 'h41);
    endtask

    task automatic t_prescale;
        logic [7:0] c;
        cfg_src_ext = 1'b0; cfg_psc_to_wdt = 1'b0; cfg_ratio = 3'd0;
        sync_change("R3"); sync_change("R3");
        c = tmr_count;
        step(7);
        chk("R3 1:2 mid", int'(tmr_count), int'(c));
        step(17);
        chk("R3 1:2", int'(tmr_count), int'(c + 8'd3));
        cfg_ratio = 3'd2;
        sync_change("R3"); sync_change("R3");
        c = tmr_count;
        step(31);
        chk("R3 1:8 mid", int'(tmr_count), int'(c));
        step(33);
        chk("R3 1:8", int'(tmr_count), int'(c + 8'd2));
    endtask

    task automatic t_psc_clear;
        cfg_src_ext = 1'b0; cfg_psc_to_wdt = 1'b0; cfg_ratio = 3'd1;
        sync_change("R6"); sync_change("R6");
        step(4);
        load(8'h10);
        step(14);
        chk("R6 held by cleared prescaler", int'(tmr_count), 'h10);
        step(1);
        chk("R6 first step", int'(tmr_count), 'h11);
    endtask

    task automatic t_external;
        logic [7:0] c;
        cfg_src_ext = 1'b1; cfg_psc_to_wdt = 1'b1; cfg_fall_edge = 1'b0;
        ext_clk = 1'b0;
        step(12);
        c = tmr_count;
        step(12);
        chk("R4 idle pin", int'(tmr_count), int'(c));
        ext_clk = 1'b1;
        step(3);
        chk("R11 not before sync", int'(tmr_count), int'(c));
        step(3);
        chk("R4 rising counted", int'(tmr_count), int'(c + 8'd1));
        ext_clk = 1'b0;
        step(8);
        chk("R4 falling ignored", int'(tmr_count), int'(c + 8'd1));
        cfg_fall_edge = 1'b1;
        step(2);
        ext_clk = 1'b1;
        step(8);
        chk("R4 rising ignored", int'(tmr_count), int'(c + 8'd1));
        ext_clk = 1'b0;
        step(6);
        chk("R4 falling counted", int'(tmr_count), int'(c + 8'd2));
        cfg_fall_edge = 1'b0;
    endtask

    task automatic t_overflow;
        bit seen;
        cfg_src_ext = 1'b0; cfg_psc_to_wdt = 1'b1;
        ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
        load(8'hFE);
        seen = 1'b0;
        for (int i = 0; i < 100 && !seen; i++) begin
            @(negedge clk);
            if (tmr_count == 8'hFF) seen = 1'b1;
        end
        chk("R7 flag clear before wrap", int'(tmr_ovf), 0);
        seen = 1'b0;
        for (int i = 0; i < 100 && !seen; i++) begin
            @(negedge clk);
            if (tmr_count == 8'h00) seen = 1'b1;
        end
        chk("R7 flag set on wrap", int'(tmr_ovf), 1);
        step(8);
        chk("R7 flag sticky", int'(tmr_ovf), 1);
        ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
        chk("R7 flag cleared", int'(tmr_ovf), 0);
        load(8'hFF);
        ovf_clr = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 100 && !seen; i++) begin
            @(negedge clk);
            if (tmr_count == 8'h00) seen = 1'b1;
        end
        chk("R7 set beats clear", int'(tmr_ovf), 1);
        step(1);
        chk("R7 clear after", int'(tmr_ovf), 0);
        ovf_clr = 1'b0;
    endtask

    task automatic t_watchdog;
        logic t;
        cfg_psc_to_wdt = 1'b1; cfg_ratio = 3'd2;
        wdt_clr = 1'b1; step(1); wdt_clr = 1'b0;
        for (int i = 0; i < 3; i++) begin
            osc_pulse(t);
            chk("R8 no tick before 4th pulse", int'(t), 0);
        end
        osc_pulse(t);
        chk("R8 tick on 4th pulse", int'(t), 1);
        step(1);
        chk("R8 tick one clock wide", int'(wdt_tick), 0);
        osc_pulse(t); osc_pulse(t);
        wdt_clr = 1'b1; step(1); wdt_clr = 1'b0;
        for (int i = 0; i < 3; i++) begin
            osc_pulse(t);
            chk("R9 clear restarts count", int'(t), 0);
        end
        osc_pulse(t);
        chk("R9 tick after clear", int'(t), 1);
        osc_pulse(t); osc_pulse(t);
        load(8'h22);
        osc_pulse(t);
        chk("R9 load leaves prescaler", int'(t), 0);
        osc_pulse(t);
        chk("R9 load leaves prescaler tick", int'(t), 1);
        cfg_ratio = 3'd0;
        osc_pulse(t);
        chk("R8 1:1 tick", int'(t), 1);
    endtask

    task automatic t_bypass;
        logic t;
        cfg_psc_to_wdt = 1'b0; cfg_ratio = 3'd3;
        step(1);
        chk("R10 idle", int'(wdt_tick), 0);
        for (int i = 0; i < 3; i++) begin
            osc_pulse(t);
            chk("R10 every pulse ticks", int'(t), 1);
        end
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_internal();
        t_load_hold();
        t_prescale();
        t_psc_clear();
        t_external();
        t_overflow();
        t_watchdog();
        t_bypass();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule